// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one channel of a DMA engine. Software programs it through a small register port: a control word, a 16-bit item count, and two base addresses, one on the peripheral side and one on the memory side. Once the channel is enabled and a peripheral raises its request line, the channel moves data one item at a time. Each item is a read beat from the source followed by a write beat to the destination, carrying the read data. The direction bit picks which side is the source. In memory-to-memory mode the channel does not wait for a request.

After each item, each side's address moves forward by that side's own item size if its increment bit is set, and the remaining count drops by one. Half-way, completion and error events come out as one-cycle pulses, each gated by its own enable bit. In circular mode the count and both addresses reload when the count reaches zero, and the channel keeps running. In one-shot mode it goes quiet with the enable bit still set. A bus error clears the enable bit in hardware. Arbitration between channels and the shared flag register belong to the surrounding controller.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, all four registers read back as zero, no bus beat is requested and no event pulse is present.
- R2: Register addresses are 0 control, 1 count, 2 peripheral address, 3 memory address. Each item is a read beat (bus_we=0) followed by a write beat (bus_we=1) whose data equals the read data and whose bus_size equals the destination item size. Control bit 4 set means the memory address (register 3) is the source and the peripheral address (register 2) is the destination. With bit 4 clear the roles swap. A beat ends on bus_ack or bus_err and holds its address until then.
- R3: Size fields are bits 9:8 (peripheral) and 11:10 (memory): 0 is 8-bit, 1 is 16-bit, 2 is 32-bit. When bit 6 (peripheral) or bit 7 (memory) is set, that side's address advances by 1, 2 or 4 bytes after each item. When the bit is clear, the address stays put.
- R4: Bus addresses and address read-back have bit 0 forced to zero for a 16-bit size, and bits 1:0 forced to zero for a 32-bit size.
- R5: The count register reads the remaining items and drops by one per completed item. In one-shot mode the channel stops at zero with control bit 0 still set. A channel enabled with a count of zero issues no beats.
- R6: While bit 0 is set, writes to the count and address registers are ignored, and a control write changes only bit 0.
- R7: With bit 5 set and bit 14 clear, reaching zero reloads the count and both addresses from their programmed values, and transfers continue.
- R8: With bit 14 set, items run without a request, and bit 5 has no effect.
- R9: Outside memory-to-memory mode, no beat starts while periph_req is low.
- R10: irq_half pulses when the remaining count becomes half the programmed count, rounded down, if bit 2 is set. irq_done pulses when it becomes zero, if bit 1 is set. For a count of one, both pulse together.
- R11: A bus error on either beat clears bit 0, stops all beats, leaves the count unchanged for that item and pulses irq_err if bit 3 is set.
- R12: chan_prio always equals control bits 13:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| periph_req | input | 1 | Peripheral transfer request (level) |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Beat address |
| bus_size | output | 2 | Beat item size code |
| bus_wdata | output | DATA_W | Write beat data |
| bus_rdata | input | DATA_W | Read beat data, valid with bus_ack |
| bus_ack | input | 1 | Beat completes |
| bus_err | input | 1 | Beat fails |
| irq_done | output | 1 | Completion pulse |
| irq_half | output | 1 | Half-way pulse |
| irq_err | output | 1 | Error pulse |
| chan_prio | output | 2 | Channel priority for the arbiter |

## Verification
The hardest state to reach from the ports is a circular channel caught in the middle of a later pass. Reaching it takes several reloads followed by a read-back of the count and addresses while a write beat is still pending. The bench's bus responder stops acknowledging writes once a chosen number of items has gone through, which freezes the channel at an exact item index for read-back. A programmable beat index injects a bus error on one chosen read or write beat. Random configurations mix sizes, misaligned bases and increment settings, and each written address and data word is compared against the bench's own model.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CFG_W = 15;

  typedef struct packed {
    logic       m2m;      // 14
    logic [1:0] prio;     // 13:12
    logic [1:0] msize;    // 11:10
    logic [1:0] psize;    // 9:8
    logic       minc;     // 7
    logic       pinc;     // 6
    logic       circ;     // 5
    logic       m2p;      // 4
    logic       ie_err;   // 3
    logic       ie_half;  // 2
    logic       ie_done;  // 1
    logic       en;       // 0
  } chan_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_state_t;

  localparam logic [1:0] RA_CFG = 2'd0;
  localparam logic [1:0] RA_CNT = 2'd1;
  localparam logic [1:0] RA_PER = 2'd2;
  localparam logic [1:0] RA_MEM = 2'd3;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] low_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    low_mask = 2'b00;
      2'd1:    low_mask = 2'b01;
      default: low_mask = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              err_clr,
  output chan_cfg_t         cfg,
  output logic [CNT_W-1:0]  base_cnt,
  output logic [ADDR_W-1:0] per_base,
  output logic [ADDR_W-1:0] mem_base
);
  chan_cfg_t         cfg_q, cfg_d;
  logic              cfg_ce;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] per_q, mem_q;
  logic              cnt_ce, per_ce, mem_ce;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_ce = 1'b0;
    if (wr_en && wr_addr == RA_CFG) begin
      cfg_ce = 1'b1;
      if (cfg_q.en) cfg_d.en = wr_data[0];
      else          cfg_d    = chan_cfg_t'(wr_data[CFG_W-1:0]);
    end
    if (err_clr) begin
      cfg_ce   = 1'b1;
      cfg_d.en = 1'b0;
    end
  end

  assign cnt_ce = wr_en && !cfg_q.en && wr_addr == RA_CNT;
  assign per_ce = wr_en && !cfg_q.en && wr_addr == RA_PER;
  assign mem_ce = wr_en && !cfg_q.en && wr_addr == RA_MEM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      per_q <= '0;
      mem_q <= '0;
    end else begin
      if (cfg_ce) cfg_q <= cfg_d;
      if (cnt_ce) cnt_q <= wr_data[CNT_W-1:0];
      if (per_ce) per_q <= wr_data[ADDR_W-1:0];
      if (mem_ce) mem_q <= wr_data[ADDR_W-1:0];
    end
  end

  assign cfg      = cfg_q;
  assign base_cnt = cnt_q;
  assign per_base = per_q;
  assign mem_base = mem_q;
endmodule

// File: rtl/dma_chan_ptr.sv
module dma_chan_ptr
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              reload,
  input  logic              step,
  input  logic              inc,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr_al
);
  logic [ADDR_W-1:0] cur_q, cur_d, mask, amt;
  logic              ce;

  assign mask    = ADDR_W'(low_mask(size));
  assign amt     = ADDR_W'(size_bytes(size));
  assign addr_al = cur_q & ~mask;
  assign ce      = load | reload | (step & inc);

  always_comb begin
    if (load)        cur_d = load_val;
    else if (reload) cur_d = base;
    else             cur_d = addr_al + amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= '0;
    else if (ce) cur_q <= cur_d;
  end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              m2m,
  input  logic              circ,
  input  logic              ie_done,
  input  logic              ie_half,
  input  logic              ie_err,
  input  logic [CNT_W-1:0]  base_cnt,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_load_val,
  input  logic              periph_req,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_phase,
  output logic              wr_phase,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              item_done,
  output logic              wrap,
  output logic              err_hit,
  output logic              irq_done,
  output logic              irq_half,
  output logic              irq_err
);
  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_d, cnt_nxt;
  logic             cnt_ce, dat_ce;
  logic             done_d, half_d, errp_d;

  assign cnt_nxt = cnt_q - 1'b1;

  always_comb begin
    st_d      = st_q;
    item_done = 1'b0;
    err_hit   = 1'b0;
    dat_ce    = 1'b0;
    case (st_q)
      ST_IDLE: if (en && cnt_q != '0 && (m2m || periph_req)) st_d = ST_RD;
      ST_RD: begin
        if (!en) st_d = ST_IDLE;
        else if (bus_err) begin
          err_hit = 1'b1;
          st_d    = ST_IDLE;
        end else if (bus_ack) begin
          dat_ce = 1'b1;
          st_d   = ST_WR;
        end
      end
      ST_WR: begin
        if (!en) st_d = ST_IDLE;
        else if (bus_err) begin
          err_hit = 1'b1;
          st_d    = ST_IDLE;
        end else if (bus_ack) begin
          item_done = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign wrap   = item_done && cnt_nxt == '0 && circ && !m2m;
  assign cnt_ce = cnt_load | item_done;

  always_comb begin
    if (cnt_load)  cnt_d = cnt_load_val;
    else if (wrap) cnt_d = base_cnt;
    else           cnt_d = cnt_nxt;
  end

  assign done_d = item_done && cnt_nxt == '0 && ie_done;
  assign half_d = item_done && cnt_nxt == (base_cnt >> 1) && ie_half;
  assign errp_d = err_hit && ie_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      data_q   <= '0;
      irq_done <= 1'b0;
      irq_half <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      st_q     <= st_d;
      if (cnt_ce) cnt_q  <= cnt_d;
      if (dat_ce) data_q <= bus_rdata;
      irq_done <= done_d;
      irq_half <= half_d;
      irq_err  <= errp_d;
    end
  end

  assign rd_phase = st_q == ST_RD && en;
  assign wr_phase = st_q == ST_WR && en;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              periph_req,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              irq_done,
  output logic              irq_half,
  output logic              irq_err,
  output logic [1:0]        chan_prio
);
  localparam int NSIDE = 2;  // 0 peripheral side, 1 memory side

  logic              rst_n_s;
  chan_cfg_t         cfg;
  logic              cfg_en;
  logic [CNT_W-1:0]  base_cnt, cnt_q;
  logic [ADDR_W-1:0] per_base, mem_base;
  logic              rd_phase, wr_phase, item_done, wrap, err_hit;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        src_size, dst_size;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  logic [ADDR_W-1:0] side_base [NSIDE];
  logic [ADDR_W-1:0] side_al   [NSIDE];
  logic              side_inc  [NSIDE];
  logic [1:0]        side_size [NSIDE];
  logic              side_load [NSIDE];

  dma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  dma_chan_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .err_clr(err_hit), .cfg(cfg), .base_cnt(base_cnt),
    .per_base(per_base), .mem_base(mem_base)
  );

  assign cfg_en = cfg.en;

  dma_chan_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .en(cfg.en), .m2m(cfg.m2m), .circ(cfg.circ),
    .ie_done(cfg.ie_done), .ie_half(cfg.ie_half), .ie_err(cfg.ie_err),
    .base_cnt(base_cnt),
    .cnt_load(reg_wr && !cfg.en && reg_addr == RA_CNT),
    .cnt_load_val(reg_wdata[CNT_W-1:0]), .periph_req(periph_req),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .data_q(data_q), .cnt_q(cnt_q),
    .item_done(item_done), .wrap(wrap), .err_hit(err_hit),
    .irq_done(irq_done), .irq_half(irq_half), .irq_err(irq_err)
  );

  assign side_base[0] = per_base;
  assign side_base[1] = mem_base;
  assign side_inc[0]  = cfg.pinc;
  assign side_inc[1]  = cfg.minc;
  assign side_size[0] = cfg.psize;
  assign side_size[1] = cfg.msize;
  assign side_load[0] = reg_wr && !cfg.en && reg_addr == RA_PER;
  assign side_load[1] = reg_wr && !cfg.en && reg_addr == RA_MEM;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_chan_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n_s), .load(side_load[g]),
      .load_val(reg_wdata[ADDR_W-1:0]), .reload(wrap), .step(item_done),
      .inc(side_inc[g]), .size(side_size[g]), .base(side_base[g]),
      .addr_al(side_al[g])
    );
  end

  assign src_addr = cfg.m2p ? side_al[1]  : side_al[0];
  assign dst_addr = cfg.m2p ? side_al[0]  : side_al[1];
  assign src_size = cfg.m2p ? cfg.msize   : cfg.psize;
  assign dst_size = cfg.m2p ? cfg.psize   : cfg.msize;

  assign bus_req   = rd_phase | wr_phase;
  assign bus_we    = wr_phase;
  assign bus_addr  = wr_phase ? dst_addr : src_addr;
  assign bus_size  = wr_phase ? dst_size : src_size;
  assign bus_wdata = data_q;
  assign chan_prio = cfg.prio;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG:  reg_rdata[CFG_W-1:0]  = cfg;
      RA_CNT:  reg_rdata[CNT_W-1:0]  = cnt_q;
      RA_PER:  reg_rdata[ADDR_W-1:0] = side_al[0];
      default: reg_rdata[ADDR_W-1:0] = side_al[1];
    endcase
  end
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              cfg_en,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  base_cnt,
  input logic [ADDR_W-1:0] per_base,
  input logic              item_done,
  input logic              wrap
);
  // R2: a pending beat keeps its address and kind until it ends
  a_r2_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=>
      !cfg_en || (bus_req && $stable(bus_addr) && $stable(bus_we)));

  a_r4_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size == 2'd1 |-> !bus_addr[0]);

  a_r4_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size[1] |-> bus_addr[1:0] == 2'b00);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    item_done && !wrap |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r7_count_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(base_cnt));

  a_r6_count_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && reg_wr && reg_addr == 2'd1 |=> $stable(base_cnt));

  a_r6_addr_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && reg_wr && reg_addr == 2'd2 |=> $stable(per_base));

  a_r11_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err |=> !cfg_en && !bus_req);
endmodule

bind dma_chan_seq dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .bus_req(bus_req), .bus_we(bus_we),
  .bus_ack(bus_ack), .bus_err(bus_err), .bus_addr(bus_addr),
  .bus_size(bus_size), .cfg_en(cfg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cnt_q(cnt_q), .base_cnt(base_cnt), .per_base(per_base),
  .item_done(item_done), .wrap(wrap)
);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        periph_req;
  logic        bus_req, bus_we, bus_ack, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size, chan_prio;
  logic        irq_done, irq_half, irq_err;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int wr_n, beat, err_beat, ack_limit;
  int n_done, n_half, n_err;
  logic [31:0] lg_addr [256];
  logic [31:0] lg_data [256];
  logic [1:0]  lg_size [256];

  always #2 clk = ~clk;

  dma_chan_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .irq_done(irq_done),
    .irq_half(irq_half), .irq_err(irq_err), .chan_prio(chan_prio)
  );

  function automatic logic [31:0] f_data(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] f_align(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return a;
    if (sz == 2'd1) return {a[31:1], 1'b0};
    return {a[31:2], 2'b00};
  endfunction
  function automatic logic [31:0] f_step(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction
  function automatic logic [31:0] mk_cfg(input bit en, idn, ihf, ier, m2p, circ,
                                         pinc, minc, input logic [1:0] psz, msz,
                                         prio, input bit m2m);
    return {17'd0, m2m, prio, msz, psz, minc, pinc, circ, m2p, ier, ihf, idn, en};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // bus responder and event counters
  initial begin
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_ack = 1'b0; bus_err = 1'b0;
      if (irq_done) n_done++;
      if (irq_half) n_half++;
      if (irq_err)  n_err++;
      if (bus_req && $urandom_range(0, 3) != 0) begin
        if (bus_we && wr_n >= ack_limit) begin
          // hold the write beat pending
        end else if (beat == err_beat) begin
          bus_err = 1'b1; beat++;
        end else begin
          bus_ack = 1'b1; beat++;
          if (bus_we) begin
            if (wr_n < 256) begin
              lg_addr[wr_n] = bus_addr; lg_data[wr_n] = bus_wdata;
              lg_size[wr_n] = bus_size;
            end
            wr_n++;
          end else bus_rdata = f_data(bus_addr);
        end
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clear_logs();
    wr_n = 0; beat = 0; err_beat = -1; ack_limit = 1 << 30;
    n_done = 0; n_half = 0; n_err = 0;
  endtask

  task automatic quiet_check(input string r, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      if (bus_req) seen++;
    end
    chk(r, seen, 0);
  endtask

  task automatic run_case(input logic [1:0] psz, msz, input bit pinc, minc, m2p,
                          m2m, circ, input int cnt, input logic [31:0] pb, mb,
                          input bit idn, ihf, ier);
    logic [31:0] c, v, sb, db, ss, ds, exp_a, exp_d;
    logic [1:0]  dsz;
    bit          circ_eff, sinc, dinc;
    int          k_tot, j, e_done, e_half, e_cnt;
    circ_eff = circ && !m2m;
    k_tot = circ_eff ? cnt * 2 + int'($urandom_range(0, cnt)) : cnt;
    clear_logs();
    periph_req = 1'b0;
    c = mk_cfg(0, idn, ihf, ier, m2p, circ, pinc, minc, psz, msz, 2'd0, m2m);
    reg_write(2'd0, c);
    reg_write(2'd1, cnt);
    reg_write(2'd2, pb);
    reg_write(2'd3, mb);
    ack_limit = k_tot;
    periph_req = !m2m;
    reg_write(2'd0, c | 32'd1);
    for (int i = 0; i < 4000 && wr_n < k_tot; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    periph_req = 1'b0;
    sb  = m2p ? f_align(mb, msz) : f_align(pb, psz);
    db  = m2p ? f_align(pb, psz) : f_align(mb, msz);
    ss  = m2p ? f_step(msz) : f_step(psz);
    ds  = m2p ? f_step(psz) : f_step(msz);
    dsz = m2p ? psz : msz;
    sinc = m2p ? minc : pinc;
    dinc = m2p ? pinc : minc;
    chk("R2/R5/R7 item count", wr_n, k_tot);
    e_done = 0; e_half = 0;
    for (int k = 0; k < k_tot && k < wr_n; k++) begin
      j = k % cnt;
      exp_a = db + (dinc ? ds * j : 32'd0);
      exp_d = f_data(sb + (sinc ? ss * j : 32'd0));
      chk("R3/R4 write address", lg_addr[k], exp_a);
      chk("R2 write data", lg_data[k], exp_d);
      chk("R2 write size", {30'd0, lg_size[k]}, {30'd0, dsz});
      if (cnt - 1 - j == 0) e_done++;
      if (cnt - 1 - j == cnt / 2) e_half++;
    end
    chk("R10 done pulses", n_done, idn ? e_done : 0);
    chk("R10 half pulses", n_half, ihf ? e_half : 0);
    j = circ_eff ? k_tot % cnt : cnt;
    e_cnt = circ_eff ? ((j == 0) ? cnt : cnt - j) : 0;
    reg_read(2'd1, v); chk("R5/R7 remaining count", v, e_cnt);
    reg_read(2'd0, v); chk("R5 enable kept", v, c | 32'd1);
    reg_read(2'd2, v);
    chk("R3/R4 peripheral address", v, f_align(pb, psz) + (pinc ? f_step(psz) * j : 0));
    reg_read(2'd3, v);
    chk("R3/R4 memory address", v, f_align(mb, msz) + (minc ? f_step(msz) * j : 0));
    if (!circ_eff) quiet_check("R5/R8 idle after last item", 10);
    reg_write(2'd0, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; periph_req = 1'b0;
    clear_logs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v); chk("R1 register reset", v, 32'd0);
    end
    chk("R1 no beat", {31'd0, bus_req}, 32'd0);
    chk("R1 no event", {29'd0, irq_done, irq_half, irq_err}, 32'd0);

    // directed: misaligned bases, mixed sizes, both increments
    run_case(2'd1, 2'd2, 1, 1, 0, 0, 0, 4, 32'h0000_1003, 32'h0000_2006, 1, 1, 1);
    // no increment, memory to peripheral
    run_case(2'd2, 2'd0, 0, 0, 1, 0, 0, 3, 32'h0000_4007, 32'h0000_5001, 1, 1, 1);
    // R7 circular
    run_case(2'd0, 2'd1, 1, 1, 0, 0, 1, 3, 32'h0000_0100, 32'h0000_0201, 1, 1, 1);
    // R8 memory-to-memory with circular set: runs once, no request
    run_case(2'd2, 2'd2, 1, 1, 1, 1, 1, 4, 32'h0000_8000, 32'h0000_9002, 1, 1, 1);
    // R10 count of one: half and done together
    run_case(2'd0, 2'd0, 1, 1, 0, 0, 0, 1, 32'h0000_0010, 32'h0000_0020, 1, 1, 0);

    // R6 lock, R9 request gating, R12 priority
    clear_logs();
    v = mk_cfg(0, 1, 1, 1, 0, 0, 1, 1, 2'd0, 2'd0, 2'd2, 0);
    reg_write(2'd0, v);
    chk("R12 priority output", {30'd0, chan_prio}, 32'd2);
    reg_write(2'd1, 32'd6);
    reg_write(2'd2, 32'h100);
    reg_write(2'd3, 32'h200);
    reg_write(2'd0, v | 32'd1);
    quiet_check("R9 no beat without request", 20);
    begin
      logic [31:0] r;
      reg_write(2'd1, 32'd9);     reg_read(2'd1, r); chk("R6 count locked", r, 32'd6);
      reg_write(2'd2, 32'h555);   reg_read(2'd2, r); chk("R6 peripheral addr locked", r, 32'h100);
      reg_write(2'd3, 32'h777);   reg_read(2'd3, r); chk("R6 memory addr locked", r, 32'h200);
      reg_write(2'd0, 32'h0000_7FFF); reg_read(2'd0, r); chk("R6 control locked", r, v | 32'd1);
      reg_write(2'd0, 32'h0000_7FFE); reg_read(2'd0, r); chk("R6 only enable changes", r, v);
    end

    // R5 zero count: enabled but no beats
    clear_logs();
    reg_write(2'd1, 32'd0);
    reg_write(2'd0, mk_cfg(1, 1, 1, 1, 0, 0, 1, 1, 2'd0, 2'd0, 2'd0, 1));
    quiet_check("R5 zero count idle", 20);
    reg_write(2'd0, 32'd0);

    // R11 error on the write beat of the third item
    clear_logs();
    err_beat = 5;
    reg_write(2'd1, 32'd5);
    reg_write(2'd2, 32'h300);
    reg_write(2'd3, 32'h400);
    periph_req = 1'b1;
    reg_write(2'd0, mk_cfg(1, 1, 1, 1, 0, 0, 1, 1, 2'd0, 2'd0, 2'd0, 0));
    for (int i = 0; i < 400 && beat <= 5; i++) @(negedge clk);
    quiet_check("R11 beats stop after error", 20);
    periph_req = 1'b0;
    chk("R11 items before error", wr_n, 2);
    chk("R11 error pulse", n_err, 1);
    chk("R11 no done pulse", n_done, 0);
    reg_read(2'd0, v); chk("R11 enable cleared", {31'd0, v[0]}, 32'd0);
    reg_read(2'd1, v); chk("R11 count kept", v, 32'd3);

    // R11 error with its pulse masked, on a read beat
    clear_logs();
    err_beat = 0;
    reg_write(2'd1, 32'd2);
    periph_req = 1'b1;
    reg_write(2'd0, mk_cfg(1, 1, 1, 0, 0, 0, 1, 1, 2'd0, 2'd0, 2'd0, 0));
    for (int i = 0; i < 200 && beat == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    periph_req = 1'b0;
    chk("R11 masked error pulse", n_err, 0);
    reg_read(2'd1, v); chk("R11 count after read error", v, 32'd2);

    // constrained random configurations
    for (int n = 0; n < 14; n++) begin
      run_case(2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0,
               1'($urandom_range(0, 1)), int'($urandom_range(1, 12)),
               $urandom, $urandom, 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 run did not end act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule